// File: doc/BRIEF.md
# Scan Velocity Modulation Drive Generator

This block turns a stream of 8-bit RGB pixels into the drive code for a scan velocity modulation coil amplifier. Each pixel is reduced to a luminance value by a fixed weighted sum. The luminance is differentiated against the value a programmable number of pixels earlier. Small differences are cored away. The rest is scaled by a gain, clamped symmetrically to a limit, and encoded offset-binary around mid-scale so that it can feed an 8-bit D/A converter directly.

Two parameter sets, each holding a span and a gain, are held on static inputs. A per-pixel select bit chooses between them. This bit is the same signal that picks video or on-screen-display colour for the main RGB outputs, and it is pipelined with the pixel it marks. Coring threshold and limit are shared by both sets.

The block runs on a clock at twice the pixel rate. It raises `pixStrobe` on every other cycle, and a pixel is taken on the rising edge that ends a strobe cycle. After the arithmetic, each result is written into a delay line at the doubled rate, once per clock. A signed output delay setting taps this line, which moves the output in half-pixel steps around a fixed base latency.

Top module: `svm_drive`

## Requirements
- R1: While `rstN` is low and in the first cycle after its release, `svmCode` is 128 and `pixStrobe` is 0. From then on `pixStrobe` alternates and is 1 in the second cycle after release.
- R2: Luminance is Y = (5·R + 9·G + 2·B) >> 4, so a grey pixel with R = G = B = v gives Y = v.
- R3: The difference for pixel k is d = Y(k) − Y(k−N), where Y before the first pixel after reset counts as 0. N is the span of the pixel's parameter set, with 0 treated as 1 and 7 treated as 6.
- R4: When |d| ≤ the coring threshold, the magnitude becomes 0. Otherwise the magnitude becomes |d| − threshold, and the sign is kept.
- R5: The cored magnitude is multiplied by the 4-bit gain of the pixel's set and shifted right by 2 (gain 4 is unity).
- R6: The scaled magnitude is clamped to the 7-bit limit, so the output stays within 128 ± limit.
- R7: The output code is 128 + m for a positive difference and 128 − m for a negative one, where m is the limited magnitude. A zero magnitude gives 128.
- R8: A pixel sampled at edge e appears on `svmCode` after edges e+13+s and e+14+s, where s is the signed delay setting in half-pixel units (−7 to +7).
- R9: `osdSel` = 1 selects span B and gain B for that pixel, and 0 selects span A and gain A. The choice takes effect on exactly the pixel it accompanies.
- R10: A delay setting of −8 behaves exactly like −7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the pixel rate |
| rstN | input | 1 | Asynchronous active-low reset |
| red | input | 8 | Red component of the pixel |
| green | input | 8 | Green component of the pixel |
| blue | input | 8 | Blue component of the pixel |
| osdSel | input | 1 | Per-pixel parameter set select (1 = set B) |
| spanA | input | 3 | Differentiator span, set A |
| spanB | input | 3 | Differentiator span, set B |
| gainA | input | 4 | Gain, set A (unity = 4) |
| gainB | input | 4 | Gain, set B (unity = 4) |
| coreLevel | input | 8 | Coring threshold |
| limitLevel | input | 7 | Symmetric output limit |
| delaySet | input | 4 | Signed output delay in half-pixel steps |
| pixStrobe | output | 1 | High in the cycle whose closing edge samples a pixel |
| svmCode | output | 8 | Offset-binary drive code for the D/A converter |

## Verification
Several properties are checked on every cycle: the alternation of the pixel strobe, the coring of any difference inside the threshold to code 128, the sign of the code relative to the sign of the difference, the clamping of every result to 128 ± limit, and the pairing of output values that a fixed half-pixel tap produces. The bench scenarios are needed for the rest. Only they can show the luminance weights and the span-dependent differentiation against earlier pixels. They also show the exact gain arithmetic, the absolute latency for each delay setting including the clamp of −8, and the per-pixel switching between the two parameter sets. In each scenario the whole output stream is compared, cycle by cycle, with an independent model.

// File: rtl/svm_pkg.sv
package svm_pkg;
  localparam int PIX_W      = 8;
  localparam int LUMA_SHIFT = 4;
  localparam int SUM_W      = PIX_W + LUMA_SHIFT;
  localparam int SPAN_MAX   = 6;
  localparam int SPAN_W     = 3;
  localparam int GAIN_W     = 4;
  localparam int GAIN_SHIFT = 2;
  localparam int LIM_W      = 7;
  localparam int DLY_W      = 4;
  localparam int DLY_MAX    = 7;
  localparam int LINE_DEPTH = 2 * DLY_MAX + 1;
  localparam int TAP_W      = $clog2(LINE_DEPTH);
  localparam int DIFF_W     = PIX_W + 1;
  localparam int PROD_W     = DIFF_W + GAIN_W;
  localparam int CODE_W     = 8;
  localparam int CODE_MID   = 1 << (CODE_W - 1);

  // strobes and selects from control to datapath
  typedef struct packed {
    logic             pixAdv;
    logic [TAP_W-1:0] tapSel;
  } svm_ctrl_t;
endpackage

// File: rtl/svm_ctrl.sv
module svm_ctrl
  import svm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [DLY_W-1:0] delaySet,
  output svm_ctrl_t               ctrl
);
  logic phaseQ;
  int   dlyInt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= 1'b0;
    else       phaseQ <= ~phaseQ;
  end

  always_comb begin
    dlyInt = int'(delaySet);
    if (dlyInt < -DLY_MAX) dlyInt = -DLY_MAX;
    if (dlyInt > DLY_MAX)  dlyInt = DLY_MAX;
    ctrl.pixAdv = phaseQ;
    ctrl.tapSel = TAP_W'(dlyInt + DLY_MAX);
  end
endmodule

// File: rtl/svm_datapath.sv
module svm_datapath
  import svm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  svm_ctrl_t                ctrl,
  input  logic [PIX_W-1:0]         red,
  input  logic [PIX_W-1:0]         green,
  input  logic [PIX_W-1:0]         blue,
  input  logic                     osdSel,
  input  logic [SPAN_W-1:0]        spanA,
  input  logic [SPAN_W-1:0]        spanB,
  input  logic [GAIN_W-1:0]        gainA,
  input  logic [GAIN_W-1:0]        gainB,
  input  logic [PIX_W-1:0]         coreLevel,
  input  logic [LIM_W-1:0]         limitLevel,
  output logic signed [DIFF_W-1:0] diffOut,
  output logic [CODE_W-1:0]        codeOut,
  output logic [CODE_W-1:0]        svmCode
);
  // stage 1: luminance and select
  logic [SUM_W-1:0]  lumaSum;
  logic [PIX_W-1:0]  yQ;
  logic              sel1Q;
  logic [PIX_W-1:0]  histQ [SPAN_MAX];

  always_comb begin
    lumaSum = SUM_W'(red) * SUM_W'(5) + SUM_W'(green) * SUM_W'(9)
            + SUM_W'(blue) * SUM_W'(2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      yQ    <= '0;
      sel1Q <= 1'b0;
      for (int i = 0; i < SPAN_MAX; i++) histQ[i] <= '0;
    end else if (ctrl.pixAdv) begin
      yQ    <= lumaSum[SUM_W-1:LUMA_SHIFT];
      sel1Q <= osdSel;
      histQ[0] <= yQ;
      for (int i = 1; i < SPAN_MAX; i++) histQ[i] <= histQ[i-1];
    end
  end

  // stage 2: span differentiator
  logic [SPAN_W-1:0]        spanRaw;
  logic [SPAN_W-1:0]        spanIdx;
  logic [PIX_W-1:0]         prevY;
  logic signed [DIFF_W-1:0] diffC;
  logic signed [DIFF_W-1:0] diffQ;
  logic                     sel2Q;

  always_comb begin
    spanRaw = sel1Q ? spanB : spanA;
    if (spanRaw == '0)                         spanIdx = '0;
    else if (spanRaw > SPAN_W'(SPAN_MAX))      spanIdx = SPAN_W'(SPAN_MAX - 1);
    else                                       spanIdx = spanRaw - SPAN_W'(1);
    prevY = histQ[spanIdx];
    diffC = $signed({1'b0, yQ}) - $signed({1'b0, prevY});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diffQ <= '0;
      sel2Q <= 1'b0;
    end else if (ctrl.pixAdv) begin
      diffQ <= diffC;
      sel2Q <= sel1Q;
    end
  end

  // stage 3: coring, gain, limit, offset-binary encode
  logic              negC;
  logic [DIFF_W-1:0] magC;
  logic [DIFF_W-1:0] coredC;
  logic [GAIN_W-1:0] gainSel;
  logic [PROD_W-1:0] prodC;
  logic [LIM_W-1:0]  limC;
  logic [CODE_W-1:0] codeC;
  logic [CODE_W-1:0] codeQ;

  always_comb begin
    negC    = diffQ[DIFF_W-1];
    magC    = negC ? DIFF_W'(-diffQ) : DIFF_W'(diffQ);
    coredC  = (magC > {1'b0, coreLevel}) ? magC - {1'b0, coreLevel} : '0;
    gainSel = sel2Q ? gainB : gainA;
    prodC   = (PROD_W'(coredC) * PROD_W'(gainSel)) >> GAIN_SHIFT;
    limC    = (prodC > PROD_W'(limitLevel)) ? limitLevel : prodC[LIM_W-1:0];
    codeC   = negC ? CODE_W'(CODE_MID) - CODE_W'(limC)
                   : CODE_W'(CODE_MID) + CODE_W'(limC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            codeQ <= CODE_W'(CODE_MID);
    else if (ctrl.pixAdv) codeQ <= codeC;
  end

  // half-pixel delay line, shifted every clock
  logic [CODE_W-1:0] lineQ [LINE_DEPTH];
  logic [CODE_W-1:0] outQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINE_DEPTH; i++) lineQ[i] <= CODE_W'(CODE_MID);
      outQ <= CODE_W'(CODE_MID);
    end else begin
      lineQ[0] <= codeQ;
      for (int i = 1; i < LINE_DEPTH; i++) lineQ[i] <= lineQ[i-1];
      outQ <= lineQ[ctrl.tapSel];
    end
  end

  assign diffOut = diffQ;
  assign codeOut = codeQ;
  assign svmCode = outQ;
endmodule

// File: rtl/svm_drive.sv
module svm_drive
  import svm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [PIX_W-1:0]        red,
  input  logic [PIX_W-1:0]        green,
  input  logic [PIX_W-1:0]        blue,
  input  logic                    osdSel,
  input  logic [SPAN_W-1:0]       spanA,
  input  logic [SPAN_W-1:0]       spanB,
  input  logic [GAIN_W-1:0]       gainA,
  input  logic [GAIN_W-1:0]       gainB,
  input  logic [PIX_W-1:0]        coreLevel,
  input  logic [LIM_W-1:0]        limitLevel,
  input  logic signed [DLY_W-1:0] delaySet,
  output logic                    pixStrobe,
  output logic [CODE_W-1:0]       svmCode
);
  svm_ctrl_t                ctrlW;
  logic signed [DIFF_W-1:0] diffW;
  logic [CODE_W-1:0]        codeW;

  svm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .delaySet(delaySet), .ctrl(ctrlW)
  );

  svm_datapath dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrlW),
    .red(red), .green(green), .blue(blue), .osdSel(osdSel),
    .spanA(spanA), .spanB(spanB), .gainA(gainA), .gainB(gainB),
    .coreLevel(coreLevel), .limitLevel(limitLevel),
    .diffOut(diffW), .codeOut(codeW), .svmCode(svmCode)
  );

  assign pixStrobe = ctrlW.pixAdv;
endmodule

// File: rtl/svm_drive_chk.sv
module svm_drive_chk
  import svm_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic                    pixStrobe,
  input logic signed [DIFF_W-1:0] diffQ,
  input logic [CODE_W-1:0]       codeQ,
  input logic [CODE_W-1:0]       svmCode,
  input logic [PIX_W-1:0]        coreLevel,
  input logic [LIM_W-1:0]        limitLevel,
  input logic signed [DLY_W-1:0] delaySet
);
  int diffMag;
  always_comb diffMag = (diffQ < 0) ? -int'(diffQ) : int'(diffQ);

  // R1
  strobe_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixStrobe |=> !pixStrobe);

  // R1
  strobe_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixStrobe |=> pixStrobe);

  // R4
  core_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixStrobe && diffMag <= int'(coreLevel)) |=> (codeQ == CODE_W'(CODE_MID)));

  // R6
  limit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixStrobe |=> ((int'(codeQ) <= CODE_MID + int'($past(limitLevel))) &&
                   (int'(codeQ) >= CODE_MID - int'($past(limitLevel)))));

  // R7
  sign_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixStrobe && diffQ > 0) |=> (codeQ >= CODE_W'(CODE_MID)));

  // R7
  sign_neg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixStrobe && diffQ < 0) |=> (codeQ <= CODE_W'(CODE_MID)));

  // R8
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (svmCode != $past(svmCode) && delaySet == $past(delaySet))
      |=> (svmCode == $past(svmCode) || delaySet != $past(delaySet)));
endmodule

bind svm_drive svm_drive_chk chk_i (
  .clk(clk), .rstN(rstN), .pixStrobe(pixStrobe),
  .diffQ(diffW), .codeQ(codeW), .svmCode(svmCode),
  .coreLevel(coreLevel), .limitLevel(limitLevel), .delaySet(delaySet)
);

// File: tb/svm_drive_tb_top.sv
module svm_drive_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_PIX    = 64;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] red, green, blue;
  logic       osdSel;
  logic [2:0] spanA, spanB;
  logic [3:0] gainA, gainB;
  logic [7:0] coreLevel;
  logic [6:0] limitLevel;
  logic signed [3:0] delaySet;
  logic       pixStrobe;
  logic [7:0] svmCode;

  int spanAI, spanBI, gainAI, gainBI, coreI, limI, delayI;
  int rArr [MAX_PIX];
  int gArr [MAX_PIX];
  int bArr [MAX_PIX];
  int sArr [MAX_PIX];
  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;

  assign spanA      = 3'(spanAI);
  assign spanB      = 3'(spanBI);
  assign gainA      = 4'(gainAI);
  assign gainB      = 4'(gainBI);
  assign coreLevel  = 8'(coreI);
  assign limitLevel = 7'(limI);
  assign delaySet   = 4'(delayI);

  svm_drive dut_i (
    .clk(clk), .rstN(rstN), .red(red), .green(green), .blue(blue),
    .osdSel(osdSel), .spanA(spanA), .spanB(spanB), .gainA(gainA),
    .gainB(gainB), .coreLevel(coreLevel), .limitLevel(limitLevel),
    .delaySet(delaySet), .pixStrobe(pixStrobe), .svmCode(svmCode)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  // model built from the requirements
  function automatic int lumaOf(int k);
    return (5 * rArr[k] + 9 * gArr[k] + 2 * bArr[k]) >> 4;
  endfunction

  function automatic int codeOf(int k);
    int n, prev, d, m, c, p;
    n = (sArr[k] != 0) ? spanBI : spanAI;
    if (n < 1) n = 1;
    if (n > 6) n = 6;
    prev = (k - n >= 0) ? lumaOf(k - n) : 0;
    d = lumaOf(k) - prev;
    m = (d < 0) ? -d : d;
    c = (m > coreI) ? m - coreI : 0;
    p = (c * ((sArr[k] != 0) ? gainBI : gainAI)) >> 2;
    if (p > limI) p = limI;
    return (d < 0) ? 128 - p : 128 + p;
  endfunction

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: edge %0d actual=%0d expected=%0d", tag, edgeCnt, actual, expected);
    end
  endtask

  task automatic setDefaults();
    spanAI = 1; spanBI = 1; gainAI = 4; gainBI = 4;
    coreI = 0; limI = 127; delayI = 0;
    for (int i = 0; i < MAX_PIX; i++) begin
      rArr[i] = 0; gArr[i] = 0; bArr[i] = 0; sArr[i] = 0;
    end
  endtask

  task automatic setGrey(int k, int v, int s);
    rArr[k] = v; gArr[k] = v; bArr[k] = v; sArr[k] = s;
  endtask

  task automatic applyReset();
    red = '0; green = '0; blue = '0; osdSel = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // streams len pixels and compares every output cycle
  task automatic runStream(string tag, int len);
    int k = 0;
    int e0 = -1;
    int sEff = delayI;
    int m;
    if (sEff < -7) sEff = -7;
    applyReset();
    for (int cyc = 0; cyc < 2 * len + 44; cyc++) begin
      m = edgeCnt - 13 - sEff;
      if (e0 < 0 || m < e0) check(tag, svmCode, 128);
      else if ((m - e0) / 2 < len) check(tag, svmCode, codeOf((m - e0) / 2));
      if (pixStrobe) begin
        if (k < len) begin
          red = 8'(rArr[k]); green = 8'(gArr[k]); blue = 8'(bArr[k]);
          osdSel = (sArr[k] != 0);
          if (k == 0) e0 = edgeCnt + 1;
          k++;
        end else begin
          red = '0; green = '0; blue = '0; osdSel = 1'b0;
        end
      end
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    setDefaults();
    red = '0; green = '0; blue = '0; osdSel = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 code in reset", svmCode, 128);
    check("R1 strobe in reset", pixStrobe, 0);
    rstN = 1'b1;
    check("R1 strobe first cycle", pixStrobe, 0);
    check("R1 code first cycle", svmCode, 128);
    @(negedge clk);
    check("R1 strobe second cycle", pixStrobe, 1);
    @(negedge clk);
    check("R1 strobe third cycle", pixStrobe, 0);
  endtask

  task automatic testLuma();
    setDefaults();
    for (int i = 0; i < 3; i++) begin rArr[i] = 255; end
    for (int i = 3; i < 6; i++) begin gArr[i] = 255; end
    for (int i = 6; i < 9; i++) begin bArr[i] = 255; end
    for (int i = 9; i < 12; i++) setGrey(i, 255, 0);
    for (int i = 15; i < 18; i++) begin rArr[i] = 40; gArr[i] = 200; bArr[i] = 90; end
    runStream("R2 R7 luma matrix and encoding", 22);
  endtask

  task automatic testSpan();
    setDefaults();
    spanAI = 3;
    for (int i = 2; i < 12; i++) setGrey(i, 100, 0);
    for (int i = 12; i < 15; i++) setGrey(i, 30, 0);
    runStream("R3 span three", 20);
    spanAI = 0;
    runStream("R3 span zero as one", 20);
    spanAI = 7;
    runStream("R3 span seven as six", 20);
  endtask

  task automatic testCoring();
    int vals[10] = '{0, 5, 15, 15, 3, 30, 8, 18, 29, 40};
    setDefaults();
    coreI = 10;
    for (int i = 0; i < 10; i++) setGrey(i, vals[i], 0);
    runStream("R4 coring", 12);
  endtask

  task automatic testGainLimit();
    setDefaults();
    gainAI = 15; limI = 40;
    for (int i = 0; i < 16; i++) setGrey(i, (i * 37) % 200, 0);
    runStream("R5 R6 high gain with limit", 18);
    gainAI = 1; limI = 127;
    runStream("R5 quarter gain", 18);
    gainAI = 7; limI = 0;
    runStream("R6 zero limit", 18);
  endtask

  task automatic testDelay();
    int settings[7] = '{-8, -7, -3, 0, 1, 5, 7};
    setDefaults();
    for (int i = 0; i < 12; i++) setGrey(i, (i % 3) * 60 + i, 0);
    for (int j = 0; j < 7; j++) begin
      delayI = settings[j];
      if (settings[j] == -8) runStream("R10 delay minus eight", 12);
      else runStream("R8 half-pixel delay", 12);
    end
  endtask

  task automatic testSelect();
    setDefaults();
    spanAI = 1; gainAI = 4; spanBI = 4; gainBI = 12; limI = 100;
    for (int i = 0; i < 20; i++) setGrey(i, (i * 23) % 120, (i % 3 == 1) ? 1 : 0);
    runStream("R9 per-pixel set select", 22);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testLuma();
    testSpan();
    testCoring();
    testGainLimit();
    testDelay();
    testSelect();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule